// File: doc/BRIEF.md
# CAN bit timing generator

This block produces the nominal bit timing for a CAN node. A prescaler divides the module clock into time quanta. A position counter then walks each bit through its four parts: a one-quantum sync segment, a propagation segment, phase segment 1 and phase segment 2. The block emits a strobe when a new bit begins, which is also the point at which a transmitter drives its next bit. It emits a second strobe at the sample point, which is the end of phase segment 1. The sampled line value comes out on a separate output.

Falling (recessive-to-dominant) edges on the receive line keep the node aligned with the bus. While the bus is idle, such an edge hard-synchronises the bit. Otherwise the bit is lengthened or shortened by the phase error, and the change never exceeds the synchronisation jump width. Sampling can use the single line value at the sample point, or a majority vote over three consecutive quanta that end at the sample point.

The configuration fields are applied through a combinational legaliser. The legaliser forces illegal values into the legal range and raises an error flag when it changes anything. The surrounding frame logic can therefore rely on a consistent timing. The reference setting is prescaler 0, segments 1 + 5 + 8 + 6 = 20 quanta and jump width 4. With a 40 MHz clock it gives 1 Mbit/s.

Top module: `can_bit_timing`

## Requirements
- R1: One time quantum lasts 2 × (brp_i + 1) clock cycles, and bit_start_o pulses for one cycle at the start of every bit.
- R2: Without edges, a bit lasts 1 + prop + ph1 + ph2 quanta. sample_o pulses exactly 1 + prop + ph1 quanta after bit_start_o, which is the end of phase segment 1.
- R3: Each of the propagation, phase 1 and phase 2 fields is held to the range 1 to 8 quanta. A value outside that range sets cfg_err_o.
- R4: If ph2 exceeds prop + ph1, ph2 is reduced to prop + ph1. If the bit would then be shorter than 8 quanta, ph1 is lengthened until the bit is exactly 8 quanta. Either adjustment sets cfg_err_o.
- R5: The jump width is held to 1 to 4 and then to at most ph2 − 1. Any adjustment sets cfg_err_o. A fully legal setting leaves cfg_err_o at 0.
- R6: Quanta are numbered from 0 at the sync segment. An edge is recognised at the boundary that ends quantum d, the first boundary at which the line is seen low. An edge with 0 < d < sample position lengthens phase 1, and therefore the bit, by min(d, jump width) quanta. An edge with d = 0 has no effect.
- R7: An edge with d at or after the sample position has an error e = (bit length − d). If e ≤ jump width, the bit restarts: quantum d becomes the sync segment, and bit_start_o comes (d + 1) quanta after the previous one. Otherwise phase 2 is shortened by the jump width.
- R8: Only recessive-to-dominant edges synchronise, and at most one resynchronisation takes place per bit. A rising edge, or a second falling edge in the same bit, has no effect.
- R9: While bus_idle_i is 1, a falling edge is a hard sync regardless of the jump width. The edge quantum becomes the sync segment, so bit_start_o comes (d + 1) quanta after the previous one. The bit that follows lasts (bit length − 1) quanta.
- R10: With triple_i at 0, bit_o takes the line value at the boundary that ends quantum (sample position − 1). With triple_i at 1, bit_o takes the majority of the values at the boundaries that end the last three quanta before the sample point. bit_o changes only together with sample_o.
- R11: While rst is 1, sample_o and bit_start_o are 0 and bit_o is 1 (recessive).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Receive line, 1 = recessive |
| bus_idle_i | input | 1 | Bus idle: a falling edge causes a hard sync |
| brp_i | input | BRP_W | Baud-rate prescaler value |
| prop_i | input | 4 | Propagation segment in quanta (1..8) |
| ph1_i | input | 4 | Phase segment 1 in quanta (1..8) |
| ph2_i | input | 4 | Phase segment 2 in quanta (1..8) |
| sjw_i | input | 4 | Synchronisation jump width in quanta (1..4) |
| triple_i | input | 1 | 1 = three-quantum majority sampling |
| bit_o | output | 1 | Sampled bit value |
| sample_o | output | 1 | One-cycle pulse at the sample point |
| bit_start_o | output | 1 | One-cycle pulse at the start of each bit (transmit point) |
| cfg_err_o | output | 1 | Configuration was adjusted by the legaliser |

## Verification
The bench uses the default prescaler width of 6 bits and drives prescaler values 0, 1 and 3. These give quanta of 2, 4 and 8 clocks, so a quantum that is miscounted by one clock shows up in the measured bit period. Segment settings span the 8-quantum minimum, the 25-quantum maximum and the reference 20-quantum bit. Together they reach every clamp of the legaliser and jump widths that are limited both by their own range and by phase segment 2. Edges are placed on exact quantum boundaries on both sides of the sample point. This probes the capped and uncapped lengthening, the restart and partial shortening branches, hard sync, and the once-per-bit rule.

// File: rtl/canbt_pkg.sv
package canbt_pkg;

    localparam int SEG_W   = 4;
    localparam int POS_W   = 6;
    localparam int SEG_MIN = 1;
    localparam int SEG_MAX = 8;
    localparam int BIT_MIN = 8;
    localparam int SJW_MAX = 4;

    typedef logic [SEG_W-1:0] seg_t;
    typedef logic [POS_W-1:0] pos_t;

    typedef struct packed {
        seg_t prop;
        seg_t ph1;
        seg_t ph2;
        seg_t sjw;
        logic err;
    } timing_t;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_HARD,
        EV_LONG,
        EV_RESTART,
        EV_SHORT
    } sync_ev_e;

    function automatic int clamp_seg(int v);
        if (v < SEG_MIN) return SEG_MIN;
        if (v > SEG_MAX) return SEG_MAX;
        return v;
    endfunction

    // Forces a raw setting into a legal one; err marks any change.
    function automatic timing_t legalize(seg_t prop, seg_t ph1, seg_t ph2, seg_t sjw);
        timing_t t;
        int      p;
        int      a;
        int      b;
        int      j;
        logic    e;
        p = clamp_seg(int'(prop));
        a = clamp_seg(int'(ph1));
        b = clamp_seg(int'(ph2));
        e = (p != int'(prop)) || (a != int'(ph1)) || (b != int'(ph2));
        if (b > p + a) begin
            b = p + a;
            e = 1'b1;
        end
        if (1 + p + a + b < BIT_MIN) begin
            a = BIT_MIN - 1 - p - b;
            e = 1'b1;
        end
        j = int'(sjw);
        if (j < 1) begin
            j = 1;
            e = 1'b1;
        end
        if (j > SJW_MAX) begin
            j = SJW_MAX;
            e = 1'b1;
        end
        if (j >= b) begin
            j = b - 1;
            e = 1'b1;
        end
        t.prop = seg_t'(p);
        t.ph1  = seg_t'(a);
        t.ph2  = seg_t'(b);
        t.sjw  = seg_t'(j);
        t.err  = e;
        return t;
    endfunction

endpackage

// File: rtl/canbt_prescaler.sv
module canbt_prescaler #(
    parameter int BRP_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [BRP_W-1:0] brp_i,
    output logic             tick_o
);

    localparam int CNT_W = BRP_W + 1;

    logic [CNT_W-1:0] cnt;

    assign tick_o = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (tick_o) begin
            cnt <= {brp_i, 1'b1};
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    // R1: a quantum is never shorter than two clocks
    assert_tick_gap_R1: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);

endmodule

// File: rtl/canbt_sequencer.sv
module canbt_sequencer
    import canbt_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    tick_i,
    input  logic    rx_i,
    input  logic    bus_idle_i,
    input  timing_t cfg_i,
    output logic    samp_now_o,
    output logic    sample_o,
    output logic    bit_start_o
);

    localparam pos_t ONE = pos_t'(1);

    pos_t     pos;
    pos_t     ext;
    pos_t     red;
    logic     rs_done;
    logic     rx_last;
    pos_t     s_eff;
    pos_t     t_eff;
    pos_t     sjw_p;
    pos_t     amt;
    pos_t     err_e;
    pos_t     t_short;
    logic     fall;
    sync_ev_e ev;

    always_comb begin
        s_eff   = ONE + pos_t'(cfg_i.prop) + pos_t'(cfg_i.ph1) + ext;
        t_eff   = s_eff + pos_t'(cfg_i.ph2) - red;
        sjw_p   = pos_t'(cfg_i.sjw);
        amt     = (pos < sjw_p) ? pos : sjw_p;
        err_e   = (pos < t_eff) ? (t_eff - pos) : '0;
        t_short = t_eff - sjw_p;
        fall    = tick_i && rx_last && !rx_i;
        ev      = EV_NONE;
        if (fall && bus_idle_i) begin
            ev = EV_HARD;
        end else if (fall && !rs_done && (pos != '0) && (sjw_p != '0)) begin
            if (pos < s_eff) begin
                ev = EV_LONG;
            end else if (err_e <= sjw_p) begin
                ev = EV_RESTART;
            end else begin
                ev = EV_SHORT;
            end
        end
        samp_now_o = tick_i && (ev == EV_NONE) && (pos == s_eff - ONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos         <= '0;
            ext         <= '0;
            red         <= '0;
            rs_done     <= 1'b0;
            rx_last     <= 1'b1;
            sample_o    <= 1'b0;
            bit_start_o <= 1'b0;
        end else begin
            sample_o    <= samp_now_o;
            bit_start_o <= 1'b0;
            if (tick_i) begin
                rx_last <= rx_i;
                unique case (ev)
                    EV_HARD, EV_RESTART: begin
                        pos         <= ONE;
                        ext         <= '0;
                        red         <= '0;
                        rs_done     <= 1'b0;
                        bit_start_o <= 1'b1;
                    end
                    EV_LONG: begin
                        ext     <= ext + amt;
                        rs_done <= 1'b1;
                        pos     <= pos + ONE;
                    end
                    EV_SHORT: begin
                        if (pos + ONE >= t_short) begin
                            pos         <= '0;
                            ext         <= '0;
                            red         <= '0;
                            rs_done     <= 1'b0;
                            bit_start_o <= 1'b1;
                        end else begin
                            red     <= red + sjw_p;
                            rs_done <= 1'b1;
                            pos     <= pos + ONE;
                        end
                    end
                    default: begin
                        if (pos + ONE >= t_eff) begin
                            pos         <= '0;
                            ext         <= '0;
                            red         <= '0;
                            rs_done     <= 1'b0;
                            bit_start_o <= 1'b1;
                        end else begin
                            pos <= pos + ONE;
                        end
                    end
                endcase
            end
        end
    end

    // R2: the sample point and the start of a bit never coincide
    assert_strobe_apart_R2: assert property (@(posedge clk) disable iff (rst)
        !(sample_o && bit_start_o));

    // R6: accumulated lengthening never exceeds the largest jump width
    assert_ext_cap_R6: assert property (@(posedge clk) disable iff (rst)
        ext <= pos_t'(SJW_MAX));

endmodule

// File: rtl/canbt_sampler.sv
module canbt_sampler (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic samp_i,
    input  logic rx_i,
    input  logic triple_i,
    output logic bit_o
);

    logic [1:0] hist;
    logic       maj;

    assign maj = (hist[1] & hist[0]) | (hist[1] & rx_i) | (hist[0] & rx_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            hist  <= 2'b11;
            bit_o <= 1'b1;
        end else begin
            if (tick_i) begin
                hist <= {hist[0], rx_i};
            end
            if (samp_i) begin
                bit_o <= triple_i ? maj : rx_i;
            end
        end
    end

    // R10: the sampled bit moves only at a sample point
    assert_bit_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !samp_i |=> $stable(bit_o));

endmodule

// File: rtl/can_bit_timing.sv
module can_bit_timing
    import canbt_pkg::*;
#(
    parameter int BRP_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_i,
    input  logic             bus_idle_i,
    input  logic [BRP_W-1:0] brp_i,
    input  logic [SEG_W-1:0] prop_i,
    input  logic [SEG_W-1:0] ph1_i,
    input  logic [SEG_W-1:0] ph2_i,
    input  logic [SEG_W-1:0] sjw_i,
    input  logic             triple_i,
    output logic             bit_o,
    output logic             sample_o,
    output logic             bit_start_o,
    output logic             cfg_err_o
);

    timing_t cfg;
    logic    tick;
    logic    samp_now;

    always_comb begin
        cfg = legalize(prop_i, ph1_i, ph2_i, sjw_i);
    end

    assign cfg_err_o = cfg.err;

    canbt_prescaler #(.BRP_W(BRP_W)) i_presc (
        .clk    (clk),
        .rst    (rst),
        .brp_i  (brp_i),
        .tick_o (tick)
    );

    canbt_sequencer i_seq (
        .clk         (clk),
        .rst         (rst),
        .tick_i      (tick),
        .rx_i        (rx_i),
        .bus_idle_i  (bus_idle_i),
        .cfg_i       (cfg),
        .samp_now_o  (samp_now),
        .sample_o    (sample_o),
        .bit_start_o (bit_start_o)
    );

    canbt_sampler i_samp (
        .clk      (clk),
        .rst      (rst),
        .tick_i   (tick),
        .samp_i   (samp_now),
        .rx_i     (rx_i),
        .triple_i (triple_i),
        .bit_o    (bit_o)
    );

endmodule

// File: tb/test_can_bit_timing.sv
module test_can_bit_timing;

    localparam int CLK_PERIOD = 10;
    localparam int BRP_W      = 6;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             rx = 1'b1;
    logic             idle = 1'b0;
    logic [BRP_W-1:0] brp = '0;
    logic [3:0]       prop = 4'd5;
    logic [3:0]       ph1 = 4'd8;
    logic [3:0]       ph2 = 4'd6;
    logic [3:0]       sjw = 4'd4;
    logic             triple = 1'b0;
    logic             bit_o;
    logic             sample_o;
    logic             bit_start_o;
    logic             cfg_err_o;

    int tests = 0;
    int fails = 0;
    int q = 2;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_bit_timing #(.BRP_W(BRP_W)) i_can_bit_timing (
        .clk         (clk),
        .rst         (rst),
        .rx_i        (rx),
        .bus_idle_i  (idle),
        .brp_i       (brp),
        .prop_i      (prop),
        .ph1_i       (ph1),
        .ph2_i       (ph2),
        .sjw_i       (sjw),
        .triple_i    (triple),
        .bit_o       (bit_o),
        .sample_o    (sample_o),
        .bit_start_o (bit_start_o),
        .cfg_err_o   (cfg_err_o)
    );

    task automatic check(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic sync_start();
        do @(negedge clk); while (!bit_start_o);
    endtask

    task automatic set_cfg(int b, int p, int a, int c, int j);
        brp  = BRP_W'(b);
        prop = 4'(p);
        ph1  = 4'(a);
        ph2  = 4'(c);
        sjw  = 4'(j);
        q    = 2 * (b + 1);
        sync_start();
        sync_start();
    endtask

    // Measures one bit; falls at quantum d, optionally rises after one quantum and falls again at d2.
    task automatic run_edges(bit wait_first, int d, int d2, output int per, output int samp);
        int c;
        samp = -1;
        if (wait_first) sync_start();
        c = 0;
        do begin
            if (c == d * q) rx = 1'b0;
            if (d2 >= 0 && c == (d + 1) * q) rx = 1'b1;
            if (d2 >= 0 && c == d2 * q) rx = 1'b0;
            @(negedge clk);
            c++;
            if (sample_o && samp < 0) samp = c;
        end while (!bit_start_o);
        per = c;
        rx = 1'b1;
    endtask

    // Line low for the bit, high between quanta hi_from and hi_to; returns the sampled bit.
    task automatic sample_run(int hi_from, int hi_to, output logic b);
        int c;
        sync_start();
        c = 0;
        do begin
            if (c == 0) rx = 1'b0;
            if (c == hi_from * q) rx = 1'b1;
            if (c == hi_to * q) rx = 1'b0;
            @(negedge clk);
            c++;
        end while (!sample_o);
        b = bit_o;
        rx = 1'b1;
    endtask

    task automatic t_reset();
        repeat (4) @(negedge clk);
        check("R11 sample_o in reset", int'(sample_o), 0);
        check("R11 bit_start_o in reset", int'(bit_start_o), 0);
        check("R11 bit_o in reset", int'(bit_o), 1);
        rst = 1'b0;
    endtask

    task automatic t_nominal();
        int per;
        int samp;
        set_cfg(0, 5, 8, 6, 4);
        check("R5 legal setting flags nothing", int'(cfg_err_o), 0);
        run_edges(1, -1, -1, per, samp);
        check("R2 reference bit period", per, 40);
        check("R2 reference sample point", samp, 28);
        set_cfg(1, 5, 8, 6, 4);
        run_edges(1, -1, -1, per, samp);
        check("R1 period with prescaler 1", per, 80);
        set_cfg(3, 2, 3, 2, 1);
        run_edges(1, -1, -1, per, samp);
        check("R1 period with prescaler 3", per, 64);
        check("R2 sample with prescaler 3", samp, 48);
    endtask

    task automatic t_clamp();
        int per;
        int samp;
        set_cfg(0, 0, 3, 3, 1);
        check("R3 zero prop flagged", int'(cfg_err_o), 1);
        run_edges(1, -1, -1, per, samp);
        check("R3 zero prop period", per, 16);
        check("R3 zero prop sample", samp, 10);
        set_cfg(0, 12, 8, 8, 4);
        check("R3 large prop flagged", int'(cfg_err_o), 1);
        run_edges(1, -1, -1, per, samp);
        check("R3 large prop period", per, 50);
        check("R3 large prop sample", samp, 34);
        set_cfg(0, 1, 1, 8, 1);
        check("R4 long ph2 flagged", int'(cfg_err_o), 1);
        run_edges(1, -1, -1, per, samp);
        check("R4 long ph2 period", per, 16);
        check("R4 long ph2 sample", samp, 12);
        set_cfg(0, 2, 2, 2, 1);
        check("R4 short bit flagged", int'(cfg_err_o), 1);
        run_edges(1, -1, -1, per, samp);
        check("R4 short bit period", per, 16);
        check("R4 short bit sample", samp, 12);
        set_cfg(0, 5, 8, 3, 4);
        check("R5 wide jump flagged", int'(cfg_err_o), 1);
        run_edges(1, 6, -1, per, samp);
        check("R5 jump limited by ph2", per, 38);
    endtask

    task automatic t_resync();
        int per;
        int samp;
        set_cfg(0, 5, 8, 6, 4);
        run_edges(1, 2, -1, per, samp);
        check("R6 lengthen by 2 period", per, 44);
        check("R6 lengthen by 2 sample", samp, 32);
        run_edges(1, 6, -1, per, samp);
        check("R6 lengthen capped period", per, 48);
        check("R6 lengthen capped sample", samp, 36);
        run_edges(1, 0, -1, per, samp);
        check("R6 edge in sync quantum", per, 40);
        run_edges(1, 17, -1, per, samp);
        check("R7 restart on small error", per, 36);
        run_edges(1, 14, -1, per, samp);
        check("R7 partial shorten period", per, 32);
        check("R7 partial shorten sample", samp, 28);
        run_edges(1, 2, 4, per, samp);
        check("R8 second edge ignored", per, 44);
        run_edges(1, 0, 100, per, samp);
        check("R8 rising edge ignored", per, 40);
    endtask

    task automatic t_hard();
        int per;
        int samp;
        set_cfg(0, 5, 8, 6, 4);
        idle = 1'b1;
        run_edges(1, 5, -1, per, samp);
        check("R9 hard sync restart", per, 12);
        run_edges(0, -1, -1, per, samp);
        check("R9 bit after hard sync", per, 38);
        run_edges(1, 9, -1, per, samp);
        check("R9 hard sync beyond jump width", per, 20);
        idle = 1'b0;
    endtask

    task automatic t_sample();
        logic b;
        set_cfg(0, 5, 8, 6, 4);
        triple = 1'b0;
        sample_run(13, 99, b);
        check("R10 single sample sees glitch", int'(b), 1);
        sample_run(99, 99, b);
        check("R10 single sample low", int'(b), 0);
        triple = 1'b1;
        sample_run(13, 99, b);
        check("R10 majority rejects glitch", int'(b), 0);
        sample_run(12, 99, b);
        check("R10 majority two of three high", int'(b), 1);
        sample_run(99, 99, b);
        check("R10 majority low", int'(b), 0);
        triple = 1'b0;
    endtask

    initial begin
        t_reset();
        t_nominal();
        t_clamp();
        t_resync();
        t_hard();
        t_sample();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule